// File: doc/BRIEF.md
# Grouped-Interrupt General-Purpose Pin Bank

This block is a bank of general-purpose pins with one word-wide register interface. Each pin has a direction bit, which makes it an output or an input, and a polarity-invert bit for input use. A value register holds the driven level of output pins and the tracked level of input pins. Two strobe registers set or clear output bits without a read-modify-write. Input pins pass through a two-flop synchroniser and then an optional inversion. Edges on the resulting effective level update the value register and an interrupt cause register.

The pins are split into groups of eight, and each group drives one interrupt line. A rising edge on an input pin whose mask bit is set asserts its group's line. A mode bit chooses how the line is released. In edge mode, software writes the cause register and leaves the group's cause bits at zero. In level mode, the line drops when falling edges have returned every value bit of the group to zero. The mask has two register addresses that share one storage.

Top module: `gpio_bank_irq`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the control register, which reads 0x11FF0000. `irq_grp`, `pin_oe` and `pin_out` are all zero.
- R2: A write to the value register (offset 2) changes only the bits whose direction bit (offset 0) is 1. Bits with direction 0 keep their value.
- R3: A write to the set register (offset 3) ORs the data into the value bits with direction 1. A write to the clear register (offset 4) clears those bits. Input bits are not touched, and both strobe registers read back as zero.
- R4: The effective level of an input pin is its synchronised level XOR its invert bit (offset 1). Changing an invert bit alone produces an edge one cycle after the write.
- R5: A rising effective edge on an input pin sets its value bit and its cause bit (offset 5). A pin change appears in the value register on the third rising clock edge after it, and not on the second.
- R6: A rising edge on a pin whose mask bit is set asserts `irq_grp[n/8]`. A rising edge on an unmasked pin sets only its cause bit.
- R7: A falling effective edge on an input pin clears its value bit and leaves its cause bit unchanged.
- R8: In level mode, a group's interrupt drops in the cycle when a falling edge leaves all eight of its value bits zero. It stays asserted while any of them is one, and cause writes do not release it.
- R9: In edge mode, a cause write that leaves a group's cause bits all zero releases that group's interrupt on the next edge. Falling edges do not release it. A rising edge in the same cycle wins.
- R10: Bit 10 of the control register (offset 8) selects level mode (1) or edge mode (0). The register reads that bit ORed with 0x11FF0000, and the other written bits are ignored.
- R11: The mask registers at offsets 6 and 7 alias one storage. A write through either offset reads back through both.
- R12: `pin_oe` equals the direction register and `pin_out` carries the value register. A pin with direction 1 ignores `pin_in`: its value and cause bits do not follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_addr | input | 4 | Word offset of the register to read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels for the pin drivers |
| pin_oe | output | 32 | Output enables, one per pin |
| irq_grp | output | 4 | Interrupt line for each group of eight pins |

## Verification
The bench measures the pin-to-register latency on both sides of the third edge. A design with a missing or extra synchroniser stage shows the new value a cycle early or a cycle late. It checks that edge mode ignores falling pins and level mode ignores cause writes, and swapping the two release rules breaks one of these checks. In level mode it drops pins one at a time, so a design that releases the line on the first falling edge, and not on the last one of the group, reports early. It also writes value, set and clear data across input bits and drives pins configured as outputs. A design that skips the direction gating shows stray value or cause bits.

// File: rtl/gpb_pkg.sv
// Shared register offsets and constants for the grouped-interrupt pin bank.
// Assumes a 32-bit register interface addressed by word offset.
package gpb_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR    = 4'd0,
        RA_INV    = 4'd1,
        RA_VAL    = 4'd2,
        RA_SET    = 4'd3,
        RA_CLR    = 4'd4,
        RA_CAUSE  = 4'd5,
        RA_MASK_A = 4'd6,
        RA_MASK_B = 4'd7,
        RA_CTRL   = 4'd8
    } reg_addr_e;

    localparam logic [DATA_W-1:0] CTRL_CONST = 32'h11FF_0000;
    localparam int unsigned       LVL_BIT    = 10;
endpackage

// File: rtl/gpb_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpb_edge.sv
// Edge detector that compares the effective input level with the stored
// value bit. Only pins configured as inputs (direction 0) produce edges.
// Assumes the value register is the only record of the last seen level.
module gpb_edge #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] eff_lvl,
    input  logic [W-1:0] value_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // A mismatch between level and stored value is an edge on an input pin.
    always_comb begin
        rise = ~dir_q &  eff_lvl & ~value_q;
        fall = ~dir_q & ~eff_lvl &  value_q;
    end
endmodule

// File: rtl/gpb_group_irq.sv
// One interrupt flop per group of GRP_SIZE pins. Set by a masked rising
// edge; released by the mode-selected rule. Setting wins over releasing.
// Assumes cause_next and value_next already hold this cycle's updates.
module gpb_group_irq #(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_SIZE = 8,
    localparam int unsigned NUM_GRPS = NUM_PINS / GRP_SIZE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] rise,
    input  logic [NUM_PINS-1:0] fall,
    input  logic [NUM_PINS-1:0] mask_q,
    input  logic [NUM_PINS-1:0] cause_next,
    input  logic [NUM_PINS-1:0] value_next,
    input  logic                cause_wr,
    input  logic                level_mode,
    output logic [NUM_GRPS-1:0] irq
);
    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        logic set_g;
        logic rel_lvl;
        logic rel_edge;
        logic irq_q;

        // Set and release conditions for this group.
        always_comb begin
            set_g    = |(rise[g*GRP_SIZE +: GRP_SIZE] & mask_q[g*GRP_SIZE +: GRP_SIZE]);
            rel_lvl  = level_mode & (|fall[g*GRP_SIZE +: GRP_SIZE])
                       & ~(|value_next[g*GRP_SIZE +: GRP_SIZE]);
            rel_edge = ~level_mode & cause_wr
                       & ~(|cause_next[g*GRP_SIZE +: GRP_SIZE]);
        end

        // Group interrupt state; set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                 irq_q <= 1'b0;
            else if (set_g)             irq_q <= 1'b1;
            else if (rel_lvl | rel_edge) irq_q <= 1'b0;
        end

        assign irq[g] = irq_q;
    end
endmodule

// File: rtl/gpio_bank_irq.sv
// Top of the pin bank: register file, read mux, synchroniser, edge
// detection and group interrupts. Register writes take effect on the
// clock edge with reg_wr high; reads are combinational from reg_addr.
// Assumes NUM_PINS <= 32 and NUM_PINS a multiple of GRP_SIZE.
module gpio_bank_irq
    import gpb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_SIZE = 8,
    localparam int unsigned NUM_GRPS = NUM_PINS / GRP_SIZE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_GRPS-1:0] irq_grp
);
    reg_addr_e          ra;
    logic [NUM_PINS-1:0] wd;
    logic [NUM_PINS-1:0] dir_q, inv_q, val_q, cause_q, mask_q;
    logic                lvl_q;
    logic [NUM_PINS-1:0] sync_lvl, eff_lvl, rise, fall;
    logic [NUM_PINS-1:0] sw_val, val_next, cause_next;
    logic                cause_wr;

    assign ra = reg_addr_e'(reg_addr);
    assign wd = reg_wdata[NUM_PINS-1:0];

    gpb_sync #(.W(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    // Apply per-pin polarity inversion.
    assign eff_lvl = sync_lvl ^ inv_q;

    gpb_edge #(.W(NUM_PINS)) edge_i (
        .eff_lvl (eff_lvl),
        .value_q (val_q),
        .dir_q   (dir_q),
        .rise    (rise),
        .fall    (fall)
    );

    // Software effect on output bits, then pin edges on input bits.
    always_comb begin
        sw_val = val_q;
        if (reg_wr) begin
            case (ra)
                RA_VAL:  sw_val = (val_q & ~dir_q) | (wd & dir_q);
                RA_SET:  sw_val = val_q | (wd & dir_q);
                RA_CLR:  sw_val = val_q & ~(wd & dir_q);
                default: sw_val = val_q;
            endcase
        end
        val_next   = (sw_val | rise) & ~fall;
        cause_wr   = reg_wr && (ra == RA_CAUSE);
        cause_next = (cause_wr ? wd : cause_q) | rise;
    end

    // Register file state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            inv_q   <= '0;
            val_q   <= '0;
            cause_q <= '0;
            mask_q  <= '0;
            lvl_q   <= 1'b0;
        end else begin
            val_q   <= val_next;
            cause_q <= cause_next;
            if (reg_wr) begin
                case (ra)
                    RA_DIR:              dir_q  <= wd;
                    RA_INV:              inv_q  <= wd;
                    RA_MASK_A, RA_MASK_B: mask_q <= wd;
                    RA_CTRL:             lvl_q  <= reg_wdata[LVL_BIT];
                    default: ;
                endcase
            end
        end
    end

    gpb_group_irq #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .mask_q     (mask_q),
        .cause_next (cause_next),
        .value_next (val_next),
        .cause_wr   (cause_wr),
        .level_mode (lvl_q),
        .irq        (irq_grp)
    );

    // Read multiplexer; strobe registers read as zero.
    always_comb begin
        case (ra)
            RA_DIR:               reg_rdata = DATA_W'(dir_q);
            RA_INV:               reg_rdata = DATA_W'(inv_q);
            RA_VAL:               reg_rdata = DATA_W'(val_q);
            RA_CAUSE:             reg_rdata = DATA_W'(cause_q);
            RA_MASK_A, RA_MASK_B: reg_rdata = DATA_W'(mask_q);
            RA_CTRL:              reg_rdata = CTRL_CONST | (DATA_W'(lvl_q) << LVL_BIT);
            default:              reg_rdata = '0;
        endcase
    end

    assign pin_out = val_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpb_checker.sv
// Property checker for the pin bank, bound to every gpio_bank_irq instance.
module gpb_checker #(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GRP_SIZE = 8,
    localparam int unsigned NUM_GRPS = NUM_PINS / GRP_SIZE
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [3:0]          reg_addr,
    input logic [31:0]         reg_rdata,
    input logic [NUM_GRPS-1:0] irq_grp,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] val_q,
    input logic [NUM_PINS-1:0] cause_q,
    input logic [NUM_PINS-1:0] mask_q,
    input logic                lvl_q
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_grp == '0 && dir_q == '0 && val_q == '0));

    assert_strobe_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd3 || reg_addr == 4'd4) |-> reg_rdata == 32'd0);

    assert_ctrl_pattern_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd8) |-> (reg_rdata[31:16] == 16'h11FF && reg_rdata[9:0] == 10'd0));

    assert_irq_needs_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_grp & ~$past(irq_grp)) != '0) |-> ((cause_q & $past(mask_q)) != '0));

    assert_outputs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && dir_q == '1) |=> $stable(val_q));

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_chk
        assert_level_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(irq_grp[g]) && !irq_grp[g] && $past(lvl_q))
            |-> val_q[g*GRP_SIZE +: GRP_SIZE] == '0);

        assert_edge_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(irq_grp[g]) && !irq_grp[g] && !$past(lvl_q))
            |-> cause_q[g*GRP_SIZE +: GRP_SIZE] == '0);
    end
endmodule

bind gpio_bank_irq gpb_checker #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_grp   (irq_grp),
    .dir_q     (dir_q),
    .val_q     (val_q),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .lvl_q     (lvl_q)
);

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = 32'd0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [3:0]  irq_grp;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gpio_bank_irq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_grp(irq_grp)
    );

    // Row: write addr, write data, read addr, expected read, requirement number
    localparam int NROWS = 11;
    localparam logic [75:0] VEC [NROWS] = '{
        {4'd0, 32'h0000FFFF, 4'd0, 32'h0000FFFF, 4'd2},  // R2 direction
        {4'd2, 32'hAAAAAAAA, 4'd2, 32'h0000AAAA, 4'd2},  // R2 outputs only
        {4'd3, 32'hFFFF00FF, 4'd2, 32'h0000AAFF, 4'd3},  // R3 set
        {4'd4, 32'h0F0F000F, 4'd2, 32'h0000AAF0, 4'd3},  // R3 clear
        {4'd3, 32'h12345678, 4'd3, 32'h00000000, 4'd3},  // R3 set reads 0
        {4'd4, 32'hFFFFFFFF, 4'd4, 32'h00000000, 4'd3},  // R3 clear reads 0
        {4'd8, 32'hFFFFFFFF, 4'd8, 32'h11FF0400, 4'd10}, // R10 level bit
        {4'd8, 32'h00000000, 4'd8, 32'h11FF0000, 4'd10}, // R10 edge mode
        {4'd6, 32'h00FF00FF, 4'd7, 32'h00FF00FF, 4'd11}, // R11 alias a->b
        {4'd7, 32'h12345678, 4'd6, 32'h12345678, 4'd11}, // R11 alias b->a
        {4'd0, 32'h00000000, 4'd0, 32'h00000000, 4'd2}   // R2 back to inputs
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pins(input logic [31:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), r);
            check("R1", r, (a == 8) ? 32'h11FF0000 : 32'h0);
        end
        check("R1", {28'd0, irq_grp}, 32'h0);
        check("R1", pin_oe, 32'h0);
        check("R1", pin_out, 32'h0);

        // Register vector table
        for (int i = 0; i < NROWS; i++) begin
            wr(VEC[i][75:72], VEC[i][71:40]);
            rd(VEC[i][39:36], r);
            check($sformatf("R%0d", VEC[i][3:0]), r, VEC[i][35:4]);
        end

        // R5 latency and R6 masked rise
        wr(4'd6, 32'h000000FF);
        @(negedge clk);
        pin_in = 32'h00000001;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(4'd2, r); check("R5 early", r, 32'h0);
        @(posedge clk);
        @(negedge clk);
        rd(4'd2, r); check("R5 value", r, 32'h1);
        rd(4'd5, r); check("R5 cause", r, 32'h1);
        check("R6 irq", {28'd0, irq_grp}, 32'h1);

        // R6 unmasked rise: cause only
        pins(32'h00000101);
        rd(4'd5, r); check("R6 cause", r, 32'h101);
        check("R6 no irq", {28'd0, irq_grp}, 32'h1);

        // R7 falling edge; R9 edge mode keeps irq
        pins(32'h00000100);
        rd(4'd2, r); check("R7 value", r, 32'h100);
        rd(4'd5, r); check("R7 cause kept", r, 32'h101);
        check("R9 fall no release", {28'd0, irq_grp}, 32'h1);

        // R9 cause write releases group 0
        wr(4'd5, 32'h00000100);
        check("R9 release", {28'd0, irq_grp}, 32'h0);
        rd(4'd5, r); check("R9 cause", r, 32'h100);

        // R8 level mode
        wr(4'd8, 32'h00000400);
        pins(32'h00000106);
        check("R8 set", {28'd0, irq_grp}, 32'h1);
        wr(4'd5, 32'h00000000);
        check("R8 cause write ignored", {28'd0, irq_grp}, 32'h1);
        pins(32'h00000104);
        check("R8 one bit left", {28'd0, irq_grp}, 32'h1);
        rd(4'd2, r); check("R8 value", r, 32'h104);
        pins(32'h00000100);
        check("R8 release", {28'd0, irq_grp}, 32'h0);

        // R4 inversion
        wr(4'd1, 32'h00010000);
        @(posedge clk);
        @(negedge clk);
        rd(4'd2, r); check("R4 value", r, 32'h00010100);
        rd(4'd5, r); check("R4 cause", r, 32'h00010000);

        // R12 output pins ignore pin_in
        wr(4'd0, 32'h01000000);
        pins(32'h01000100);
        rd(4'd2, r); check("R12 value", r, 32'h00010100);
        rd(4'd5, r); check("R12 cause", r, 32'h00010000);
        check("R12 oe", pin_oe, 32'h01000000);
        wr(4'd3, 32'h01000000);
        check("R12 out", pin_out & pin_oe, 32'h01000000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule